// File: doc/BRIEF.md
# Wait-for-Interrupt / Wait-for-Event Sleep Controller

This per-core controller stops the core's clock when the core issues a wait-for-interrupt (WFI) or wait-for-event (WFE) request, and later decides when the clock comes back. A sleeping core burns only leakage. A WFI sleep ends only on an interrupt, a debug request or a reset request. A WFE sleep ends on any of those and also on any event source: a broadcast send-event, a local send-event, a periodic timer event, or the exclusive monitor dropping from Exclusive to Open.

A one-bit sticky event flag inside the block records events. Events set it at any time, including while the core is awake or parked in a WFI sleep. A WFE that finds the flag set consumes it and completes at once without gating the clock. This means a peer's signal that arrives just before the core goes to sleep is never lost.

Completion is reported on `instr_done`, a single-cycle pulse. On a wake from sleep, the clock-enable comes back one cycle before that pulse.

The controller is a five-state machine:
- `ST_AWAKE`: idle and running.
- `ST_DOZE_INT`: gated, waiting for an interrupt-class source.
- `ST_DOZE_EVT`: gated, waiting for any source.
- `ST_RESUME`: clock back on, instruction not yet done.
- `ST_RETIRE`: done pulse.

The named transitions are:
- sleep-int: AWAKE→DOZE_INT.
- sleep-evt: AWAKE→DOZE_EVT.
- fast-retire: AWAKE→RETIRE, taken when a wake source or a pending event is present with the request.
- wake: DOZE_*→RESUME.
- finish: RESUME→RETIRE.
- return: RETIRE→AWAKE.

Top module: `wake_gate_ctrl`

## Requirements
- R1: After reset, `core_clk_en`=1, `core_asleep`=0 and `instr_done`=0, and the event flag is clear, so a first WFE with no source active goes to sleep.
- R2: A WFI request in `ST_AWAKE` with no interrupt-class source active drives `core_clk_en` low and `core_asleep` high from the next cycle. The core stays gated while no interrupt-class source is active.
- R3: A WFI sleep ends only on `irq_req`, `dbg_req` or `rst_req`. The four event inputs never end it, but they do set the event flag.
- R4: A WFE sleep ends on any interrupt-class source or on any of `sev_bcast`, `sev_local`, `timer_evt` or `mon_clr_evt`.
- R5: The event flag is set by any event input while the core is awake or in a WFI sleep. A later WFE then completes with `instr_done` one cycle after the request, and `core_clk_en` never drops.
- R6: Any WFE completion clears the event flag, including an event that arrives in the waking cycle itself. The next WFE with no source active therefore sleeps.
- R7: In the cycle after a wake source is seen in a sleep state, `core_clk_en`=1 with `instr_done`=0. In the cycle after that, `instr_done` is 1 for exactly one cycle.
- R8: A request that arrives together with a valid wake source for its kind completes with `instr_done` in the next cycle, without gating the clock. For WFE, an event arriving with the request is consumed and not left pending.
- R9: Requests are taken only in `ST_AWAKE` and are ignored in `ST_RESUME` and `ST_RETIRE`. When both requests are raised together, WFI is taken, and the WFE request neither consumes the event flag nor has any other effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Ungated clock of the controller |
| rst_n | input | 1 | Active-low asynchronous reset of the controller |
| wfi_req | input | 1 | Core requests a wait-for-interrupt sleep |
| wfe_req | input | 1 | Core requests a wait-for-event sleep |
| irq_req | input | 1 | Pending interrupt (wakes WFI and WFE) |
| dbg_req | input | 1 | Debug request (wakes WFI and WFE) |
| rst_req | input | 1 | Core reset request (wakes WFI and WFE) |
| sev_bcast | input | 1 | Send-event broadcast from another core |
| sev_local | input | 1 | Send-event raised by this core |
| timer_evt | input | 1 | Periodic timer event stream pulse |
| mon_clr_evt | input | 1 | Exclusive monitor went Exclusive→Open |
| core_clk_en | output | 1 | Clock enable for the core's clock gate |
| core_asleep | output | 1 | Core is parked in a gated sleep state |
| instr_done | output | 1 | One-cycle pulse completing the wait instruction |

## Verification
A stuck or wrongly set event flag stays invisible until the next WFE. At that point the core either sleeps when it should return at once, or returns when it should sleep, so `core_clk_en` and `instr_done` differ in the very next cycle. A wrong state shows at the ports within one or two cycles, through the clock-enable, the sleep flag or a misplaced done pulse. The bench's reference model runs beside the design and compares all three outputs every cycle, so the first divergent cycle is the one reported. The directed sequences place events before requests, during WFI sleeps and in the same cycle as requests, so that any lost or unconsumed event becomes visible.

// File: rtl/wgc_pkg.sv
package wgc_pkg;

    typedef enum logic [2:0] {
        ST_AWAKE    = 3'd0,
        ST_DOZE_INT = 3'd1,
        ST_DOZE_EVT = 3'd2,
        ST_RESUME   = 3'd3,
        ST_RETIRE   = 3'd4
    } wgc_state_t;

    localparam int unsigned WGC_INT_SRCS = 3;
    localparam int unsigned WGC_EVT_SRCS = 4;

endpackage

// File: rtl/wgc_wake_merge.sv
module wgc_wake_merge #(
    parameter int unsigned INT_W = 3,
    parameter int unsigned EVT_W = 4
) (
    input  logic [INT_W-1:0] int_src,
    input  logic [EVT_W-1:0] evt_src,
    output logic             int_wake,
    output logic             evt_wake
);

    logic [INT_W:0] int_chain;
    logic [EVT_W:0] evt_chain;

    assign int_chain[0] = 1'b0;
    assign evt_chain[0] = 1'b0;

    for (genvar i = 0; i < INT_W; i++) begin : g_int
        assign int_chain[i+1] = int_chain[i] | int_src[i];
    end

    for (genvar j = 0; j < EVT_W; j++) begin : g_evt
        assign evt_chain[j+1] = evt_chain[j] | evt_src[j];
    end

    assign int_wake = int_chain[INT_W];
    assign evt_wake = evt_chain[EVT_W];

endmodule

// File: rtl/wgc_event_latch.sv
module wgc_event_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic pending_o
);

    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end
    end

    assign pending_o = pend_q;

    AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !pend_q) else $error("consume did not clear flag"); // R6

    AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !clr_i) |=> pend_q) else $error("flag lost"); // R5

endmodule

// File: rtl/wgc_fsm.sv
module wgc_fsm
    import wgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic int_wake,
    input  logic evt_wake,
    input  logic ev_pending,
    output logic clk_en,
    output logic asleep,
    output logic done,
    output logic ev_clr
);

    wgc_state_t state_q;
    wgc_state_t state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_AWAKE: begin
                if (wfi_req) begin
                    state_d = int_wake ? ST_RETIRE : ST_DOZE_INT;
                end else if (wfe_req) begin
                    state_d = (int_wake || evt_wake || ev_pending) ? ST_RETIRE : ST_DOZE_EVT;
                end
            end
            ST_DOZE_INT: begin
                if (int_wake) state_d = ST_RESUME;
            end
            ST_DOZE_EVT: begin
                if (int_wake || evt_wake) state_d = ST_RESUME;
            end
            ST_RESUME: state_d = ST_RETIRE;
            ST_RETIRE: state_d = ST_AWAKE;
            default:   state_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_AWAKE;
        else        state_q <= state_d;
    end

    always_comb begin
        clk_en = 1'b1;
        asleep = 1'b0;
        done   = 1'b0;
        ev_clr = 1'b0;
        unique case (state_q)
            ST_AWAKE: begin
                ev_clr = wfe_req && !wfi_req;
            end
            ST_DOZE_INT: begin
                clk_en = 1'b0;
                asleep = 1'b1;
            end
            ST_DOZE_EVT: begin
                clk_en = 1'b0;
                asleep = 1'b1;
                ev_clr = int_wake || evt_wake;
            end
            ST_RESUME: begin
                clk_en = 1'b1;
            end
            ST_RETIRE: begin
                done = 1'b1;
            end
            default: begin
                clk_en = 1'b1;
            end
        endcase
    end

    AST_DONE_AFTER_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(clk_en)) else $error("done without prior clock"); // R7

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done) else $error("done longer than one cycle"); // R7

    AST_WFI_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE_INT && !int_wake) |=> asleep) else $error("WFI woke on event"); // R3

    AST_WFE_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DOZE_EVT && (int_wake || evt_wake)) |=> (clk_en && !done)) else $error("WFE missed wake"); // R4

    AST_PENDING_NO_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_AWAKE && wfe_req && !wfi_req && ev_pending) |=> (done && clk_en)) else $error("pending event slept"); // R5

    AST_BUSY_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RETIRE) |=> !asleep) else $error("request taken while busy"); // R9

endmodule

// File: rtl/wake_gate_ctrl.sv
module wake_gate_ctrl
    import wgc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wfi_req,
    input  logic wfe_req,
    input  logic irq_req,
    input  logic dbg_req,
    input  logic rst_req,
    input  logic sev_bcast,
    input  logic sev_local,
    input  logic timer_evt,
    input  logic mon_clr_evt,
    output logic core_clk_en,
    output logic core_asleep,
    output logic instr_done
);

    logic [WGC_INT_SRCS-1:0] int_vec;
    logic [WGC_EVT_SRCS-1:0] evt_vec;
    logic int_wake;
    logic evt_wake;
    logic ev_pending;
    logic ev_clr;

    assign int_vec = {rst_req, dbg_req, irq_req};
    assign evt_vec = {mon_clr_evt, timer_evt, sev_local, sev_bcast};

    wgc_wake_merge #(
        .INT_W (WGC_INT_SRCS),
        .EVT_W (WGC_EVT_SRCS)
    ) u_merge (
        .int_src  (int_vec),
        .evt_src  (evt_vec),
        .int_wake (int_wake),
        .evt_wake (evt_wake)
    );

    wgc_event_latch u_evreg (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (evt_wake),
        .clr_i     (ev_clr),
        .pending_o (ev_pending)
    );

    wgc_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .wfi_req    (wfi_req),
        .wfe_req    (wfe_req),
        .int_wake   (int_wake),
        .evt_wake   (evt_wake),
        .ev_pending (ev_pending),
        .clk_en     (core_clk_en),
        .asleep     (core_asleep),
        .done       (instr_done),
        .ev_clr     (ev_clr)
    );

    AST_GATED_MEANS_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (core_asleep && !irq_req && !dbg_req && !rst_req && wfe_req) |=> !instr_done) else $error("done while gated"); // R2

endmodule

// File: tb/wake_gate_ctrl_test.sv
module wake_gate_ctrl_test;

    localparam int B_WFI = 1;
    localparam int B_WFE = 2;
    localparam int B_IRQ = 4;
    localparam int B_DBG = 8;
    localparam int B_RST = 16;
    localparam int B_SG  = 32;
    localparam int B_SL  = 64;
    localparam int B_TM  = 128;
    localparam int B_MC  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wfi_req = 0, wfe_req = 0, irq_req = 0, dbg_req = 0, rst_req = 0;
    logic sev_bcast = 0, sev_local = 0, timer_evt = 0, mon_clr_evt = 0;
    logic core_clk_en, core_asleep, instr_done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    wake_gate_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .wfi_req(wfi_req), .wfe_req(wfe_req),
        .irq_req(irq_req), .dbg_req(dbg_req), .rst_req(rst_req),
        .sev_bcast(sev_bcast), .sev_local(sev_local),
        .timer_evt(timer_evt), .mon_clr_evt(mon_clr_evt),
        .core_clk_en(core_clk_en), .core_asleep(core_asleep),
        .instr_done(instr_done)
    );

    // reference model: 0 running, 1 wfi sleep, 2 wfe sleep, 3 waking, 4 completing
    int  m_mode = 0;
    bit  m_flag = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode <= 0;
            m_flag <= 0;
        end else begin
            bit iw, ew, take_e, wake_e;
            iw = irq_req | dbg_req | rst_req;
            ew = sev_bcast | sev_local | timer_evt | mon_clr_evt;
            take_e = (m_mode == 0) && wfe_req && !wfi_req;
            wake_e = (m_mode == 2) && (iw || ew);
            if (take_e || wake_e) m_flag <= 0;
            else if (ew)          m_flag <= 1;
            if (m_mode == 0) begin
                if (wfi_req)      m_mode <= iw ? 4 : 1;
                else if (wfe_req) m_mode <= (iw || ew || m_flag) ? 4 : 2;
            end else if (m_mode == 1) begin
                if (iw) m_mode <= 3;
            end else if (m_mode == 2) begin
                if (iw || ew) m_mode <= 3;
            end else if (m_mode == 3) begin
                m_mode <= 4;
            end else begin
                m_mode <= 0;
            end
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            logic [2:0] exp_v, got_v;
            exp_v = {(m_mode != 1 && m_mode != 2), (m_mode == 1 || m_mode == 2), (m_mode == 4)};
            got_v = {core_clk_en, core_asleep, instr_done};
            checks++;
            if (got_v !== exp_v) begin
                errors++;
                $display("FAIL %s model compare: en/sl/dn got %b expected %b at cycle %0d", cur_req, got_v, exp_v, cycles);
            end
        end
    end

    task automatic tick(input int v);
        wfi_req     = (v & B_WFI) != 0;
        wfe_req     = (v & B_WFE) != 0;
        irq_req     = (v & B_IRQ) != 0;
        dbg_req     = (v & B_DBG) != 0;
        rst_req     = (v & B_RST) != 0;
        sev_bcast   = (v & B_SG)  != 0;
        sev_local   = (v & B_SL)  != 0;
        timer_evt   = (v & B_TM)  != 0;
        mon_clr_evt = (v & B_MC)  != 0;
        @(negedge clk);
    endtask

    task automatic chk(input logic en, input logic sl, input logic dn, input string tag);
        checks++;
        if ({core_clk_en, core_asleep, instr_done} !== {en, sl, dn}) begin
            errors++;
            $display("FAIL %s: en/sl/dn got %b%b%b expected %b%b%b", tag,
                     core_clk_en, core_asleep, instr_done, en, sl, dn);
        end
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got running expected finished");
            finish_run();
        end
    end

    initial begin
        @(negedge clk);
        tick(0); tick(0);
        rst_n = 1'b1;
        cur_req = "R1";
        chk(1, 0, 0, "R1 reset outputs");
        tick(B_WFE);          chk(0, 1, 0, "R1 flag clear after reset");
        cur_req = "R2";
        tick(0);              chk(0, 1, 0, "R2 wfe stays gated");
        cur_req = "R7";
        tick(B_SL);           chk(1, 0, 0, "R7 clock before done");
        tick(0);              chk(1, 0, 1, "R7 done pulse");
        tick(0);              chk(1, 0, 0, "R7 done single");

        cur_req = "R2";
        tick(B_WFI);          chk(0, 1, 0, "R2 wfi gates");
        for (int k = 0; k < 20; k++) begin
            tick(0);
        end
        chk(0, 1, 0, "R2 wfi long sleep");
        cur_req = "R3";
        tick(B_SG | B_SL | B_TM | B_MC); chk(0, 1, 0, "R3 events ignored by wfi");
        tick(B_IRQ);          chk(1, 0, 0, "R3 irq wakes wfi");
        tick(0); tick(0);

        cur_req = "R5";
        tick(B_WFE);          chk(1, 0, 1, "R5 flag from wfi sleep");
        tick(0);
        cur_req = "R6";
        tick(B_WFE);          chk(0, 1, 0, "R6 flag consumed");
        cur_req = "R4";
        tick(B_DBG);          chk(1, 0, 0, "R4 dbg wakes wfe");
        tick(0); tick(0);

        cur_req = "R5";
        tick(B_TM);           chk(1, 0, 0, "R5 event while awake");
        tick(0);
        tick(B_WFE);          chk(1, 0, 1, "R5 early event kept");
        tick(0);

        cur_req = "R8";
        tick(B_WFI | B_RST);  chk(1, 0, 1, "R8 wfi with reset req");
        tick(0);
        tick(B_WFE | B_MC);   chk(1, 0, 1, "R8 wfe with event");
        tick(0);
        tick(B_WFE);          chk(0, 1, 0, "R8 same-cycle event consumed");
        cur_req = "R6";
        tick(B_SG | B_SL);    chk(1, 0, 0, "R6 wake event");
        tick(0); tick(0);
        tick(B_WFE);          chk(0, 1, 0, "R6 waking event not kept");
        tick(B_IRQ); tick(0); tick(0);

        cur_req = "R9";
        tick(B_WFI | B_WFE);  chk(0, 1, 0, "R9 wfi wins");
        tick(B_SL);           chk(0, 1, 0, "R9 taken as wfi");
        tick(B_IRQ);          chk(1, 0, 0, "R9 wake");
        tick(B_WFI);          chk(1, 0, 1, "R9 ignored in resume");
        tick(B_WFE);          chk(1, 0, 0, "R9 ignored in retire");
        cur_req = "R5";
        tick(B_WFE);          chk(1, 0, 1, "R5 flag survived ignored req");
        tick(0);

        cur_req = "R4";
        for (int s = 0; s < 4; s++) begin
            int src;
            src = (s == 0) ? B_IRQ : (s == 1) ? B_RST : (s == 2) ? B_SG : B_TM;
            tick(B_WFE);      chk(0, 1, 0, "R4 wfe sleeps");
            tick(src);        chk(1, 0, 0, "R4 source wakes wfe");
            tick(0); tick(0);
        end
        cur_req = "R3";
        for (int s = 0; s < 2; s++) begin
            tick(B_WFI);      chk(0, 1, 0, "R3 wfi sleeps");
            tick(s == 0 ? B_DBG : B_RST); chk(1, 0, 0, "R3 dbg/rst wakes wfi");
            tick(0); tick(0);
        end
        finish_run();
    end

endmodule